// File: doc/BRIEF.md
# Scripted I2C Bus Master

This block is an I2C bus master that runs a short transaction script. The host writes script entries into an internal buffer and then pulses `go`. The block then works through the entries one bus phase at a time. It advances only on cycles where `tick` is high. It drives SCL and SDA as open-drain pull-down enables and samples SDA for acknowledges. Bytes received from the slave go into a small result store, which the host reads back by slot number. When the script ends the block pulses `done`. If an acknowledge is missing it pulses `err` and stops.

Each script entry is 9 bits wide. Bit 8 clear marks a data byte in bits 7:0, which is sent as it stands. Bit 8 set marks a control token, and bits 1:0 select the token: 0 is repeated START, 1 is STOP, 2 is READ one byte, 3 is END of script. Bits 7:2 of a token are ignored. A register write is scripted as: address with bit 0 clear, register index, data, STOP, END. A register read is scripted as: write address, register index, START, address with bit 0 set, READ, STOP, END. The first entry must be a data byte, and DEPTH must be a power of two.

Sequencer states and transitions. IDLE goes to ST0 when `go` is seen. ST0 (both lines high) goes to ST1 (SCL high, SDA low), then to ST2 (both low, first byte loaded). TX_S, TX_H and TX_L move each bit through SCL low, high and low. After the eighth bit the sequencer goes to TXACK_H. There a high SDA takes it back to IDLE with an error; a low SDA takes it on to TXACK_L. RX_S, RX_H and RX_L receive one bit each. After eight bits the sequencer goes to RXACK_H and then RXACK_L. TXACK_L and RXACK_L both dispatch on the next entry: a data entry goes to TX_S, START to ST0, STOP to SP1, READ to RX_S, and END to IDLE with `done`. SP1 to SP4 form the stop sequence, and SP4 returns to IDLE with `done`.

Top module: `i2c_script_master`

## Requirements
- R1: After reset, both pull enables are low, `done` and `err` are low, and every result slot reads 0.
- R2: A transaction opens with a start condition: SDA falls while SCL is released, over three ticks (both high, SDA low, both low).
- R3: Each transmitted byte goes out MSB first, one bit per three ticks. The bit is set with SCL low, held while SCL is high, and held as SCL falls.
- R4: If SDA is high when the acknowledge is sampled after a transmitted byte, `err` pulses, `done` does not, and both lines are released.
- R5: Entry bit 8 separates tokens from data. A data entry whose low bits equal a token code (for example 0x03) is still sent as a byte.
- R6: A START token produces a new start condition with no stop condition before it.
- R7: READ clocks eight bits MSB first into a cleared byte. Received bytes are stored in consecutive result slots from slot 0.
- R8: After a received byte the master drives ACK (SDA low) if the next entry is READ, and NAK (SDA released) otherwise.
- R9: STOP gives four ticks (both low, SCL high with SDA low, both high, held), then `done`. The bus is left released.
- R10: Pull enables, `done` and `err` change only on cycles where `tick` is high. With `tick` held low the bus is frozen.
- R11: `done` and `err` are single-cycle pulses and are never high together.
- R12: END without a stop finishes with `done` and leaves SCL pulled low and SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_we | input | 1 | Write one script entry |
| load_addr | input | clog2(DEPTH) | Script slot to write |
| load_entry | input | 9 | Entry: bit 8 token flag, bits 7:0 data or token code |
| go | input | 1 | Start running the script from slot 0 (taken in IDLE) |
| tick | input | 1 | Bus phase enable |
| sda_in | input | 1 | Sampled SDA line level |
| rd_addr | input | clog2(RX_DEPTH) | Result slot to read |
| rd_byte | output | 8 | Received byte in the selected slot |
| scl_pull | output | 1 | Pull SCL low when high |
| sda_pull | output | 1 | Pull SDA low when high |
| done | output | 1 | Script finished (pulse) |
| err | output | 1 | Missing acknowledge (pulse) |

## Verification
A wrong sequencer state would show up at the pins within one tick. Examples are an SDA edge while SCL is released outside a start or stop, a missing start seen by the bench slave model, or a byte arriving with the wrong bit order. A wrong index or lookahead would show up one byte later: a data value taken as a token, a wrong ACK/NAK on a read, or a result stored in the wrong slot. The bench then sees the wrong outcome pulse or reads the wrong slot contents. Stall faults show up as pin activity while `tick` is held low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ENTRY_W = 9;

    localparam logic [1:0] CODE_START = 2'd0;
    localparam logic [1:0] CODE_STOP  = 2'd1;
    localparam logic [1:0] CODE_READ  = 2'd2;
    localparam logic [1:0] CODE_END   = 2'd3;

    typedef enum logic [4:0] {
        S_IDLE, S_ST0, S_ST1, S_ST2,
        S_TX_S, S_TX_H, S_TX_L, S_TXACK_H, S_TXACK_L,
        S_RX_S, S_RX_H, S_RX_L, S_RXACK_H, S_RXACK_L,
        S_SP1, S_SP2, S_SP3, S_SP4
    } state_t;

    function automatic logic is_read_tok(input logic [ENTRY_W-1:0] e);
        return e[ENTRY_W-1] && (e[1:0] == CODE_READ);
    endfunction

endpackage

// File: rtl/i2cs_script_ram.sv
module i2cs_script_ram
    import i2cs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NPORT = 2
) (
    input  logic                                clk,
    input  logic                                we,
    input  logic [$clog2(DEPTH)-1:0]            waddr,
    input  logic [ENTRY_W-1:0]                  wdata,
    input  logic [$clog2(DEPTH)-1:0]            rbase,
    output logic [NPORT-1:0][ENTRY_W-1:0]       rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // port g reads the entry g places after the base (wrapping)
    for (genvar g = 0; g < NPORT; g++) begin : g_rd
        assign rdata[g] = mem[rbase + AW'(g)];
    end

endmodule

// File: rtl/i2cs_rx_store.sv
module i2cs_rx_store #(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [7:0]               wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [7:0]               rdata
);
    logic [7:0] slot [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (we) begin
            slot[waddr] <= wdata;
        end
    end

    assign rdata = slot[raddr];

endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
    import i2cs_pkg::*;
#(
    parameter int AW = 3,
    parameter int RW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               tick,
    input  logic               sda_in,
    input  logic [ENTRY_W-1:0] cur_ent,
    input  logic [ENTRY_W-1:0] nxt_ent,
    output logic [AW-1:0]      idx,
    output logic               rx_we,
    output logic [RW-1:0]      rx_idx,
    output logic [7:0]         rx_byte,
    output logic               scl_lvl,
    output logic               sda_lvl,
    output logic               done,
    output logic               err
);
    state_t      st, st_n;
    logic [AW-1:0] idx_n;
    logic [RW-1:0] ridx, ridx_n;
    logic [7:0]  sh, sh_n;
    logic [3:0]  cnt, cnt_n;
    logic        scl_n, sda_n, done_n, err_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            idx     <= '0;
            ridx    <= '0;
            sh      <= '0;
            cnt     <= '0;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            st      <= st_n;
            idx     <= idx_n;
            ridx    <= ridx_n;
            sh      <= sh_n;
            cnt     <= cnt_n;
            scl_lvl <= scl_n;
            sda_lvl <= sda_n;
            done    <= done_n;
            err     <= err_n;
        end
    end

    // next state and next bus levels
    always_comb begin
        st_n   = st;
        idx_n  = idx;
        ridx_n = ridx;
        sh_n   = sh;
        cnt_n  = cnt;
        scl_n  = scl_lvl;
        sda_n  = sda_lvl;
        done_n = 1'b0;
        err_n  = 1'b0;
        if (st == S_IDLE) begin
            if (go) begin
                st_n   = S_ST0;
                idx_n  = '0;
                ridx_n = '0;
            end
        end else if (tick) begin
            unique case (st)
                S_ST0: begin scl_n = 1'b1; sda_n = 1'b1; st_n = S_ST1; end
                S_ST1: begin scl_n = 1'b1; sda_n = 1'b0; st_n = S_ST2; end
                S_ST2: begin
                    scl_n = 1'b0; sda_n = 1'b0;
                    sh_n  = cur_ent[7:0];
                    cnt_n = 4'd8;
                    st_n  = S_TX_S;
                end
                S_TX_S: begin scl_n = 1'b0; sda_n = sh[7]; st_n = S_TX_H; end
                S_TX_H: begin scl_n = 1'b1; sda_n = sh[7]; st_n = S_TX_L; end
                S_TX_L: begin
                    scl_n = 1'b0;
                    sh_n  = {sh[6:0], 1'b0};
                    cnt_n = cnt - 4'd1;
                    if (cnt == 4'd1) begin
                        sda_n = 1'b1;
                        st_n  = S_TXACK_H;
                    end else begin
                        sda_n = sh[7];
                        st_n  = S_TX_S;
                    end
                end
                S_TXACK_H: begin
                    scl_n = 1'b1; sda_n = 1'b1;
                    if (sda_in) begin
                        err_n = 1'b1;
                        st_n  = S_IDLE;
                    end else begin
                        st_n  = S_TXACK_L;
                    end
                end
                S_TXACK_L, S_RXACK_L: begin
                    scl_n = 1'b0;
                    if (st == S_RXACK_L) ridx_n = ridx + RW'(1);
                    if (!nxt_ent[ENTRY_W-1]) begin
                        sh_n  = nxt_ent[7:0];
                        cnt_n = 4'd8;
                        idx_n = idx + AW'(1);
                        st_n  = S_TX_S;
                    end else begin
                        unique case (nxt_ent[1:0])
                            CODE_START: begin idx_n = idx + AW'(2); st_n = S_ST0; end
                            CODE_STOP:  begin idx_n = idx + AW'(2); st_n = S_SP1; end
                            CODE_READ: begin
                                idx_n = idx + AW'(1);
                                sh_n  = '0;
                                cnt_n = 4'd8;
                                st_n  = S_RX_S;
                            end
                            default: begin done_n = 1'b1; st_n = S_IDLE; end
                        endcase
                    end
                end
                S_RX_S: begin scl_n = 1'b0; sda_n = 1'b1; st_n = S_RX_H; end
                S_RX_H: begin scl_n = 1'b1; sda_n = 1'b1; st_n = S_RX_L; end
                S_RX_L: begin
                    scl_n = 1'b0;
                    sh_n  = {sh[6:0], sda_in};
                    cnt_n = cnt - 4'd1;
                    if (cnt == 4'd1) begin
                        sda_n = !is_read_tok(nxt_ent);
                        st_n  = S_RXACK_H;
                    end else begin
                        sda_n = 1'b1;
                        st_n  = S_RX_S;
                    end
                end
                S_RXACK_H: begin scl_n = 1'b1; st_n = S_RXACK_L; end
                S_SP1: begin scl_n = 1'b0; sda_n = 1'b0; st_n = S_SP2; end
                S_SP2: begin scl_n = 1'b1; sda_n = 1'b0; st_n = S_SP3; end
                S_SP3: begin scl_n = 1'b1; sda_n = 1'b1; st_n = S_SP4; end
                S_SP4: begin
                    scl_n = 1'b1; sda_n = 1'b1;
                    done_n = 1'b1;
                    st_n   = S_IDLE;
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // result store write port
    assign rx_we   = (st == S_RXACK_L) && tick;
    assign rx_idx  = ridx;
    assign rx_byte = sh;

endmodule

// File: rtl/i2c_script_master.sv
module i2c_script_master
    import i2cs_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int RX_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_we,
    input  logic [$clog2(DEPTH)-1:0]    load_addr,
    input  logic [ENTRY_W-1:0]          load_entry,
    input  logic                        go,
    input  logic                        tick,
    input  logic                        sda_in,
    input  logic [$clog2(RX_DEPTH)-1:0] rd_addr,
    output logic [7:0]                  rd_byte,
    output logic                        scl_pull,
    output logic                        sda_pull,
    output logic                        done,
    output logic                        err
);
    localparam int AW = $clog2(DEPTH);
    localparam int RW = $clog2(RX_DEPTH);

    logic [AW-1:0]             idx;
    logic [1:0][ENTRY_W-1:0]   ents;
    logic                      rx_we;
    logic [RW-1:0]             rx_idx;
    logic [7:0]                rx_byte;
    logic                      scl_lvl, sda_lvl;

    i2cs_script_ram #(.DEPTH(DEPTH), .NPORT(2)) u_ram (
        .clk   (clk),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_entry),
        .rbase (idx),
        .rdata (ents)
    );

    i2cs_seq #(.AW(AW), .RW(RW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tick    (tick),
        .sda_in  (sda_in),
        .cur_ent (ents[0]),
        .nxt_ent (ents[1]),
        .idx     (idx),
        .rx_we   (rx_we),
        .rx_idx  (rx_idx),
        .rx_byte (rx_byte),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .done    (done),
        .err     (err)
    );

    i2cs_rx_store #(.DEPTH(RX_DEPTH)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rx_we),
        .waddr (rx_idx),
        .wdata (rx_byte),
        .raddr (rd_addr),
        .rdata (rd_byte)
    );

    assign scl_pull = !scl_lvl;
    assign sda_pull = !sda_lvl;

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic scl_pull,
    input logic sda_pull,
    input logic done,
    input logic err
);
    // R10: frozen bus while tick is low
    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(scl_pull) && $stable(sda_pull)));

    // R10: outcome pulses only follow a tick
    assert_pulse_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> $past(tick));

    // R11: never both
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R11: single-cycle pulses
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R4: abort leaves both lines released
    assert_err_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!scl_pull && !sda_pull));

endmodule

bind i2c_script_master i2cs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .done     (done),
    .err      (err)
);

// File: tb/i2c_script_master_tb_top.sv
module i2c_script_master_tb_top;

    localparam logic [6:0] SLV_ADDR = 7'h50;
    localparam logic [8:0] T_START = 9'h100;
    localparam logic [8:0] T_STOP  = 9'h101;
    localparam logic [8:0] T_READ  = 9'h102;
    localparam logic [8:0] T_END   = 9'h103;
    localparam int NV = 5;
    // {read, addr7, reg, data, slave nacks data, expect err}
    localparam logic [25:0] VECS [NV] = '{
        {1'b0, 7'h50, 8'h12, 8'hA5, 1'b0, 1'b0},
        {1'b0, 7'h50, 8'h02, 8'h03, 1'b0, 1'b0},
        {1'b1, 7'h50, 8'h07, 8'h3C, 1'b0, 1'b0},
        {1'b0, 7'h21, 8'h10, 8'h55, 1'b0, 1'b1},
        {1'b0, 7'h50, 8'h11, 8'h66, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_we = 1'b0;
    logic [2:0] load_addr = '0;
    logic [8:0] load_entry = '0;
    logic       go = 1'b0;
    logic       tick;
    logic       sda_in;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_byte;
    logic       scl_pull, sda_pull, done, err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bit tick_on = 1'b1;
    int tcnt = 0;
    always @(negedge clk) tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
    assign tick = tick_on && (tcnt == 2);

    i2c_script_master dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_we    (load_we),
        .load_addr  (load_addr),
        .load_entry (load_entry),
        .go         (go),
        .tick       (tick),
        .sda_in     (sda_in),
        .rd_addr    (rd_addr),
        .rd_byte    (rd_byte),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .done       (done),
        .err        (err)
    );

    // ---------------- slave model ----------------
    logic slv_pull = 1'b0;
    wire  scl_l = !scl_pull;
    wire  sda_l = !(sda_pull || slv_pull);
    assign sda_in = sda_l;

    bit   p_scl = 1'b1, p_sda = 1'b1;
    bit   first = 1'b1, rd_mode = 1'b0, ignore = 1'b1, last_mack = 1'b0;
    bit   nack_data = 1'b0;
    int   bcnt = 0, start_cnt = 0, stop_cnt = 0, wr_n = 0, mack_n = 0, rptr = 0;
    logic [7:0] sh_s = '0;
    logic [7:0] wr_log [64];
    bit         mack [64];
    int         stops_at_start [64];
    logic [7:0] rd_src [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_l && p_scl && p_sda && !sda_l) begin
                stops_at_start[start_cnt % 64] = stop_cnt;
                start_cnt++;
                bcnt = 0; first = 1; rd_mode = 0; ignore = 0; slv_pull = 0;
            end else if (scl_l && p_scl && !p_sda && sda_l) begin
                stop_cnt++;
                ignore = 1; slv_pull = 0;
            end else if (!ignore && scl_l && !p_scl) begin
                if (bcnt < 8) begin
                    if (!rd_mode) sh_s = {sh_s[6:0], sda_l};
                end else if (bcnt == 8 && rd_mode && !first) begin
                    last_mack = !sda_l;
                    mack[mack_n % 64] = !sda_l;
                    mack_n++;
                end
                bcnt++;
            end else if (!ignore && !scl_l && p_scl) begin
                if (bcnt >= 1 && bcnt <= 7 && rd_mode && !first) begin
                    slv_pull = !rd_src[rptr % 64][7-bcnt];
                end else if (bcnt == 8) begin
                    if (first) begin
                        if (sh_s[7:1] == SLV_ADDR) begin
                            slv_pull = 1; rd_mode = sh_s[0];
                        end else begin
                            ignore = 1;
                        end
                    end else if (rd_mode) begin
                        slv_pull = 0; rptr++;
                    end else begin
                        wr_log[wr_n % 64] = sh_s; wr_n++;
                        slv_pull = !nack_data;
                    end
                end else if (bcnt == 9) begin
                    bcnt = 0;
                    if (rd_mode && (first || last_mack)) slv_pull = !rd_src[rptr % 64][7];
                    else slv_pull = 0;
                    first = 0;
                end
            end
        end
        p_scl = scl_l;
        p_sda = sda_l;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [8:0] scr [8];

    task automatic load_go(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load_we = 1; load_addr = 3'(i); load_entry = scr[i];
        end
        @(negedge clk);
        load_we = 0; go = 1;
        @(negedge clk);
        go = 0;
    endtask

    task automatic wait_end(output bit gd, output bit ge, output int width);
        gd = 0; ge = 0; width = 0;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            if (done || err) begin
                gd = done; ge = err; width = 1;
                @(negedge clk);
                if (done || err) width = 2;
                break;
            end
        end
    endtask

    task automatic read_slot(input int s, output logic [7:0] b);
        @(negedge clk);
        rd_addr = 2'(s);
        #1 b = rd_byte;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        bit gd, ge;
        int w, s0, w0, m0, st0;
        logic [7:0] b;
        bit frozen;
        logic sp, dp;

        repeat (4) @(negedge clk);
        chk("R1 pulls in reset", {30'd0, scl_pull, sda_pull}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pulses after reset", {30'd0, done, err}, 0);
        read_slot(0, b);
        chk("R1 result slot cleared", b, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic rw, snack, experr;
            logic [6:0] a7;
            logic [7:0] rg, dt;
            {rw, a7, rg, dt, snack, experr} = VECS[v];
            nack_data = snack;
            s0 = start_cnt; st0 = stop_cnt; w0 = wr_n; m0 = mack_n;
            rd_src[rptr % 64] = dt;
            if (!rw) begin
                scr[0] = {1'b0, a7, 1'b0}; scr[1] = {1'b0, rg}; scr[2] = {1'b0, dt};
                scr[3] = T_STOP; scr[4] = T_END;
                load_go(5);
            end else begin
                scr[0] = {1'b0, a7, 1'b0}; scr[1] = {1'b0, rg}; scr[2] = T_START;
                scr[3] = {1'b0, a7, 1'b1}; scr[4] = T_READ; scr[5] = T_STOP; scr[6] = T_END;
                load_go(7);
            end
            wait_end(gd, ge, w);
            chk("R4 err outcome", ge, experr);
            chk("R4 done outcome", gd, !experr);
            chk("R11 pulse width", w, 1);
            if (experr) begin
                chk("R4 bus released on abort", {30'd0, scl_pull, sda_pull}, 0);
            end else if (!rw) begin
                chk("R2 one start seen", start_cnt - s0, 1);
                chk("R3 register byte", wr_log[w0 % 64], rg);
                chk("R5 data byte sent", wr_log[(w0 + 1) % 64], dt);
                chk("R9 stop seen", stop_cnt - st0, 1);
                chk("R9 bus released", {30'd0, scl_pull, sda_pull}, 0);
            end else begin
                chk("R2 two starts seen", start_cnt - s0, 2);
                chk("R6 no stop before restart",
                    stops_at_start[(s0 + 1) % 64] - stops_at_start[s0 % 64], 0);
                read_slot(0, b);
                chk("R7 received byte", b, dt);
                chk("R8 NAK on last read", mack[m0 % 64], 0);
                chk("R9 stop seen", stop_cnt - st0, 1);
            end
        end
        nack_data = 0;

        // two consecutive reads: ACK then NAK, slots 0 and 1
        m0 = mack_n;
        rd_src[rptr % 64] = 8'h81;
        rd_src[(rptr + 1) % 64] = 8'h5E;
        scr[0] = {1'b0, SLV_ADDR, 1'b0}; scr[1] = 9'h020; scr[2] = T_START;
        scr[3] = {1'b0, SLV_ADDR, 1'b1}; scr[4] = T_READ; scr[5] = T_READ;
        scr[6] = T_STOP; scr[7] = T_END;
        load_go(8);
        wait_end(gd, ge, w);
        chk("R7 double read done", gd, 1);
        read_slot(0, b);
        chk("R7 slot 0", b, 8'h81);
        read_slot(1, b);
        chk("R7 slot 1", b, 8'h5E);
        chk("R8 ACK before next read", mack[m0 % 64], 1);
        chk("R8 NAK on final read", mack[(m0 + 1) % 64], 0);

        // tick stall mid transaction
        w0 = wr_n;
        scr[0] = {1'b0, SLV_ADDR, 1'b0}; scr[1] = 9'h0C3; scr[2] = 9'h03C;
        scr[3] = T_STOP; scr[4] = T_END;
        load_go(5);
        repeat (40) @(negedge clk);
        tick_on = 0;
        @(negedge clk);
        sp = scl_pull; dp = sda_pull;
        frozen = 1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (scl_pull != sp || sda_pull != dp || done || err) frozen = 0;
        end
        chk("R10 bus frozen without tick", frozen, 1);
        tick_on = 1;
        wait_end(gd, ge, w);
        chk("R10 finishes after stall", gd, 1);
        chk("R3 byte after stall", wr_log[(w0 + 1) % 64], 8'h3C);

        // END without stop
        st0 = stop_cnt;
        scr[0] = {1'b0, SLV_ADDR, 1'b0}; scr[1] = 9'h044; scr[2] = T_END;
        load_go(3);
        wait_end(gd, ge, w);
        chk("R12 done on end token", gd, 1);
        chk("R12 SCL held low, SDA released", {30'd0, scl_pull, sda_pull}, 2);
        chk("R12 no stop issued", stop_cnt - st0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule